// File: doc/BRIEF.md
# Dual-Buffer Flash Operation Arbiter

This block sits between a command decoder and the datapath of a flash device that has one main array and two page-sized SRAM buffers. Each cycle it may receive one decoded command. It answers every command with a single-cycle accept or reject pulse. It keeps track of the one array operation that may be in flight and of the buffer that operation holds. It drives an active-low busy pin and a status byte. It also enforces write protection on the low pages.

Commands fall into two classes. Array-class commands occupy the main array for a number of cycles. Each opcode has its own cycle count, held in a small table that a configuration port can rewrite. Buffer reads, buffer writes and status reads never touch the array. They are therefore accepted while an array operation runs, as long as they do not aim at the buffer that operation holds. This lets software fill one buffer while the other one is being programmed.

An active-low asynchronous reset aborts whatever is running and forces the block to idle. The block stays idle for as long as the reset is held.

Top module: `flash_op_arbiter`

## Requirements
- R1: While rst_n is low, the block shows its idle state: status = 8'h80, busy_n = 1, lock_valid = 0, err_flag = 0, op_done = 0, no accept or reject pulse. An operation in progress is abandoned, and commands presented during reset get no accept.
- R2: An array-class command (opcodes 0 to 8) presented while status bit 7 is 0 is rejected, and the running operation continues unchanged.
- R3: Buffer read (9), buffer write (10) and status read (11) are accepted while an array operation runs, provided they do not target the locked buffer.
- R4: Transfer (1), compare (2), program with erase (3), program without erase (4), program through buffer (7) and auto rewrite (8) lock the buffer named by cmd_buf for their whole duration. During that time lock_valid = 1 and lock_buf shows the locked buffer. Page read (0), page erase (5) and block erase (6) lock no buffer.
- R5: A buffer read or write aimed at the locked buffer is rejected and sets err_flag, which is also status bit 0. Only reset clears it.
- R6: busy_n is 0 while any array operation other than page read runs. It is 1 when idle and during a page read.
- R7: Status bit 7 is 0 from the cycle after an array command is accepted until that operation ends, and 1 otherwise. Bits 5 to 1 read 0.
- R8: An accepted array operation with table count N keeps the block busy for max(N,1) cycles. In the last of those cycles op_done is 1 for exactly one cycle, the block returns to ready, and the buffer lock is released.
- R9: Status bit 6 takes the value of cmp_diff sampled on the final cycle of a compare. It is unchanged at every other time.
- R10: With wp_n = 0, opcodes 3 to 8 targeting pages 0 to 255 are rejected and have no effect. Page read and transfer are never refused for protection.
- R11: cfg_we with cfg_op in 0 to 8 writes cfg_cycles into that opcode's count, which applies to later operations. Reset restores every count to DEF_CYCLES.
- R12: Each command with cmd_valid = 1 yields exactly one of cmd_ack or cmd_nak, one cycle later. Opcodes 12 to 15 are rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset and abort |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 4 | Decoded opcode |
| cmd_buf | input | 1 | Buffer select (0 or 1) |
| cmd_page | input | PAGE_W | Target page address |
| wp_n | input | 1 | Write protect, active low |
| cmp_diff | input | 1 | Compare mismatch result from the datapath |
| cfg_we | input | 1 | Cycle-count table write enable |
| cfg_op | input | 4 | Opcode whose count is written |
| cfg_cycles | input | CNT_W | New cycle count |
| cmd_ack | output | 1 | Command accepted (one-cycle pulse) |
| cmd_nak | output | 1 | Command rejected (one-cycle pulse) |
| busy_n | output | 1 | Active-low busy pin |
| status | output | 8 | Ready (7), compare mismatch (6), lock error (0) |
| lock_valid | output | 1 | A buffer is locked |
| lock_buf | output | 1 | Index of the locked buffer |
| op_done | output | 1 | Array operation finished (one-cycle pulse) |
| err_flag | output | 1 | Sticky locked-buffer access error |

## Verification
The assertions take for granted that cmd_op, cmd_buf and cmd_page are meaningful only when cmd_valid is high. They also assume at most one command arrives per cycle, and that cmp_diff is settled during the final cycle of a compare. The stimulus respects these assumptions: it changes inputs only at falling clock edges, keeps cmp_diff constant across an entire compare, and deasserts cmd_valid right after each accepting edge. Commands aimed at busy or locked resources are issued on purpose only inside an operation's known busy window, where the expected reject can be predicted.

// File: rtl/flash_op_arbiter.sv
module flash_op_arbiter #(
  parameter int PAGE_W     = 10,
  parameter int CNT_W      = 16,
  parameter int PROT_PAGES = 256,
  parameter int DEF_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [3:0]        cmd_op,
  input  logic              cmd_buf,
  input  logic [PAGE_W-1:0] cmd_page,
  input  logic              wp_n,
  input  logic              cmp_diff,
  input  logic              cfg_we,
  input  logic [3:0]        cfg_op,
  input  logic [CNT_W-1:0]  cfg_cycles,
  output logic              cmd_ack,
  output logic              cmd_nak,
  output logic              busy_n,
  output logic [7:0]        status,
  output logic              lock_valid,
  output logic              lock_buf,
  output logic              op_done,
  output logic              err_flag
);

  localparam logic [3:0] OP_PRD  = 4'd0;
  localparam logic [3:0] OP_XFR  = 4'd1;
  localparam logic [3:0] OP_CMP  = 4'd2;
  localparam logic [3:0] OP_PGE  = 4'd3;
  localparam logic [3:0] OP_PGN  = 4'd4;
  localparam logic [3:0] OP_ERP  = 4'd5;
  localparam logic [3:0] OP_ERB  = 4'd6;
  localparam logic [3:0] OP_PTB  = 4'd7;
  localparam logic [3:0] OP_ARW  = 4'd8;
  localparam logic [3:0] OP_BRD  = 4'd9;
  localparam logic [3:0] OP_BWR  = 4'd10;
  localparam logic [3:0] OP_STS  = 4'd11;
  localparam logic [3:0] NUM_ARR = 4'd9;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic             act, cur_buf, miss;
  logic [3:0]       cur_op;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cyc_tab [16];
  logic             is_arr, is_bufop, is_stat, is_prot, prot_hit, locked_hit, grant, cur_uses_buf;
  logic [CNT_W-1:0] load_val, start_cnt;

  assign is_arr     = cmd_op < NUM_ARR;
  assign is_bufop   = (cmd_op == OP_BRD) || (cmd_op == OP_BWR);
  assign is_stat    = cmd_op == OP_STS;
  assign is_prot    = (cmd_op >= OP_PGE) && (cmd_op <= OP_ARW);
  assign prot_hit   = is_prot && !wp_n && (32'(cmd_page) < PROT_PAGES);
  assign locked_hit = is_bufop && lock_valid && (cmd_buf == cur_buf);
  assign grant      = cmd_valid &&
                      (is_arr ? (!act && !prot_hit) : (is_bufop ? !locked_hit : is_stat));
  assign load_val   = cyc_tab[cmd_op];
  assign start_cnt  = (load_val == '0) ? ONE : load_val;

  assign cur_uses_buf = (cur_op == OP_XFR) || (cur_op == OP_CMP) || (cur_op == OP_PGE) ||
                        (cur_op == OP_PGN) || (cur_op == OP_PTB) || (cur_op == OP_ARW);
  assign lock_valid = act && cur_uses_buf;
  assign lock_buf   = cur_buf;
  assign busy_n     = !(act && (cur_op != OP_PRD));
  assign status     = {!act, miss, 5'b0, err_flag};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act      <= 1'b0;
      cur_op   <= OP_PRD;
      cur_buf  <= 1'b0;
      cnt      <= '0;
      miss     <= 1'b0;
      err_flag <= 1'b0;
      op_done  <= 1'b0;
      cmd_ack  <= 1'b0;
      cmd_nak  <= 1'b0;
      for (int i = 0; i < 16; i++) cyc_tab[i] <= CNT_W'(DEF_CYCLES);
    end else begin
      cmd_ack <= grant;
      cmd_nak <= cmd_valid && !grant;
      op_done <= 1'b0;
      if (cfg_we && (cfg_op < NUM_ARR)) cyc_tab[cfg_op] <= cfg_cycles;
      if (cmd_valid && locked_hit) err_flag <= 1'b1;
      if (act) begin
        if (cnt == ONE) begin
          act     <= 1'b0;
          op_done <= 1'b1;
          if (cur_op == OP_CMP) miss <= cmp_diff;
        end else begin
          cnt <= cnt - ONE;
        end
      end else if (grant && is_arr) begin
        act     <= 1'b1;
        cur_op  <= cmd_op;
        cur_buf <= cmd_buf;
        cnt     <= start_cnt;
      end
    end
  end

  // R2
  array_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && is_arr && !status[7]) |=> cmd_nak);

  // R5
  lock_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && is_bufop && lock_valid && (cmd_buf == lock_buf)) |=> (cmd_nak && err_flag));

  // R5
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag);

  // R6
  busy_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_n |-> !status[7]);

  // R4
  lock_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_valid |-> !status[7]);

  // R8
  done_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_done |-> (status[7] && !lock_valid));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_done |=> !op_done);

  // R10
  write_prot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && is_prot && !wp_n && (32'(cmd_page) < PROT_PAGES)) |=> cmd_nak);

  // R12
  one_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> (cmd_ack != cmd_nak));

  // R12
  no_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> (!cmd_ack && !cmd_nak));

endmodule

// File: tb/flash_op_arbiter_bench.sv
module flash_op_arbiter_bench;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, cmd_valid, cmd_buf, wp_n, cmp_diff, cfg_we;
  logic [3:0] cmd_op, cfg_op;
  logic [9:0] cmd_page;
  logic [15:0] cfg_cycles;
  logic cmd_ack, cmd_nak, busy_n, lock_valid, lock_buf, op_done, err_flag;
  logic [7:0] status;

  flash_op_arbiter u_flash_op_arbiter (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_buf(cmd_buf),
    .cmd_page(cmd_page), .wp_n(wp_n), .cmp_diff(cmp_diff), .cfg_we(cfg_we), .cfg_op(cfg_op),
    .cfg_cycles(cfg_cycles), .cmd_ack(cmd_ack), .cmd_nak(cmd_nak), .busy_n(busy_n),
    .status(status), .lock_valid(lock_valid), .lock_buf(lock_buf), .op_done(op_done),
    .err_flag(err_flag));

  typedef struct {string tag; logic ack;} exp_t;
  exp_t q[$];
  int vectors = 0;
  int miscmp = 0;

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      miscmp++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  always @(negedge clk) begin
    exp_t e;
    if (q.size() > 0) begin
      e = q.pop_front();
      chk({e.tag, " ack"}, cmd_ack, e.ack);
      chk({e.tag, " nak"}, cmd_nak, !e.ack);
    end
  end

  task automatic issue(string tag, logic [3:0] op, logic b, int pg, logic exp_ack);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_buf = b; cmd_page = pg[9:0];
    @(posedge clk); #1;
    q.push_back('{tag, exp_ack});
    cmd_valid = 1'b0;
  endtask

  task automatic cfg(logic [3:0] op, int n);
    @(negedge clk);
    cfg_we = 1'b1; cfg_op = op; cfg_cycles = n[15:0];
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic wait_ready(string tag);
    int n = 0;
    @(negedge clk);
    while (!status[7] && n < 100) begin
      @(negedge clk);
      n++;
    end
    chk({tag, " finishes"}, status[7], 1'b1);
  endtask

  task automatic run();
    rst_n = 1'b0; cmd_valid = 0; cmd_op = 0; cmd_buf = 0; cmd_page = 0;
    wp_n = 1'b1; cmp_diff = 0; cfg_we = 0; cfg_op = 0; cfg_cycles = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset status", status, 8'h80);
    chk("R1 reset busy_n", busy_n, 1);
    chk("R1 reset lock", lock_valid, 0);
    chk("R1 reset err", err_flag, 0);
    chk("R1 reset replies", {cmd_ack, cmd_nak, op_done}, 0);
    rst_n = 1'b1;

    // R8 R11 timing with a programmed count of 5
    cfg(4'd1, 5);
    issue("R4 transfer", 4'd1, 1'b0, 10, 1'b1);
    @(negedge clk);
    chk("R6 busy during transfer", busy_n, 0);
    chk("R7 not ready", status[7], 0);
    chk("R4 lock valid", lock_valid, 1);
    chk("R4 lock buf0", lock_buf, 0);
    repeat (4) @(negedge clk);
    chk("R8 no done at cycle 5", op_done, 0);
    chk("R8 still busy at cycle 5", status[7], 0);
    @(negedge clk);
    chk("R8 done pulse", op_done, 1);
    chk("R8 ready after count", status[7], 1);
    chk("R6 busy released", busy_n, 1);
    chk("R8 lock released", lock_valid, 0);
    @(negedge clk);
    chk("R8 done single cycle", op_done, 0);

    // R8 zero count acts as one
    cfg(4'd1, 0);
    issue("R8 transfer zero count", 4'd1, 1'b1, 11, 1'b1);
    @(negedge clk);
    chk("R8 zero count busy", status[7], 0);
    @(negedge clk);
    chk("R8 zero count done", op_done, 1);

    // concurrency
    cfg(4'd4, 30);
    issue("R4 program buf1", 4'd4, 1'b1, 300, 1'b1);
    issue("R3 write free buf0", 4'd10, 1'b0, 0, 1'b1);
    issue("R5 read locked buf1", 4'd9, 1'b1, 0, 1'b0);
    issue("R2 page read while busy", 4'd0, 1'b0, 0, 1'b0);
    issue("R2 erase while busy", 4'd5, 1'b0, 400, 1'b0);
    issue("R3 status read", 4'd11, 1'b0, 0, 1'b1);
    issue("R3 read free buf0", 4'd9, 1'b0, 0, 1'b1);
    issue("R2 transfer while busy", 4'd1, 1'b0, 0, 1'b0);
    @(negedge clk);
    chk("R5 err set", err_flag, 1);
    chk("R5 status bit0", status[0], 1);
    chk("R4 lock buf1", lock_buf, 1);
    chk("R6 busy during program", busy_n, 0);
    wait_ready("R2 program");
    chk("R4 lock released", lock_valid, 0);
    chk("R5 err sticky", err_flag, 1);
    issue("R5 read buf1 after release", 4'd9, 1'b1, 0, 1'b1);
    @(negedge clk);
    chk("R5 err still sticky", err_flag, 1);

    // page read does not pull the pin
    cfg(4'd0, 4);
    issue("R6 page read", 4'd0, 1'b0, 7, 1'b1);
    @(negedge clk);
    chk("R6 page read pin high", busy_n, 1);
    chk("R7 page read status busy", status[7], 0);
    chk("R4 page read no lock", lock_valid, 0);
    wait_ready("R7 page read");

    // write protect
    cfg(4'd5, 3);
    cfg(4'd6, 3);
    wp_n = 1'b0;
    issue("R10 erase page 255", 4'd5, 1'b0, 255, 1'b0);
    @(negedge clk);
    chk("R10 refused erase no effect", status[7], 1);
    issue("R10 erase page 256", 4'd5, 1'b0, 256, 1'b1);
    wait_ready("R10 erase 256");
    issue("R10 block erase page 0", 4'd6, 1'b0, 0, 1'b0);
    issue("R10 program page 3", 4'd4, 1'b0, 3, 1'b0);
    issue("R10 auto rewrite page 100", 4'd8, 1'b1, 100, 1'b0);
    @(negedge clk);
    chk("R10 refused program no effect", {status[7], lock_valid}, 2'b10);
    issue("R10 page read page 0", 4'd0, 1'b0, 0, 1'b1);
    wait_ready("R10 page read");
    issue("R10 transfer page 5", 4'd1, 1'b0, 5, 1'b1);
    wait_ready("R10 transfer");
    wp_n = 1'b1;
    issue("R10 erase page 0 unprotected", 4'd5, 1'b0, 0, 1'b1);
    wait_ready("R10 erase 0");

    // compare result
    cfg(4'd2, 6);
    cmp_diff = 1'b1;
    issue("R9 compare mismatch", 4'd2, 1'b1, 20, 1'b1);
    @(negedge clk);
    chk("R9 bit6 before finish", status[6], 0);
    chk("R4 compare locks buf1", {lock_valid, lock_buf}, 2'b11);
    wait_ready("R9 compare 1");
    chk("R9 mismatch recorded", status[6], 1);
    cmp_diff = 1'b0;
    issue("R9 compare match", 4'd2, 1'b0, 21, 1'b1);
    @(negedge clk);
    chk("R9 bit6 held mid compare", status[6], 1);
    wait_ready("R9 compare 2");
    chk("R9 match recorded", status[6], 0);

    // illegal opcodes
    issue("R12 opcode 13", 4'd13, 1'b0, 0, 1'b0);
    issue("R12 opcode 15", 4'd15, 1'b1, 0, 1'b0);
    @(negedge clk);
    chk("R12 illegal no effect", status, 8'h81);

    // reset abort
    cfg(4'd7, 50);
    issue("R1 program through buffer", 4'd7, 1'b0, 500, 1'b1);
    repeat (3) @(negedge clk);
    chk("R1 running before reset", busy_n, 0);
    rst_n = 1'b0;
    #1;
    chk("R1 abort status", status, 8'h80);
    chk("R1 abort busy_n", busy_n, 1);
    chk("R1 abort lock", lock_valid, 0);
    chk("R1 abort err cleared", err_flag, 0);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 4'd1; cmd_buf = 1'b0; cmd_page = 10'd9;
    @(posedge clk); #1;
    chk("R1 no accept in reset", {cmd_ack, cmd_nak}, 0);
    cmd_valid = 1'b0;
    repeat (4) @(negedge clk);
    chk("R1 held idle", {status, busy_n}, {8'h80, 1'b1});
    rst_n = 1'b1;

    issue("R11 transfer default count", 4'd1, 1'b0, 9, 1'b1);
    repeat (8) @(negedge clk);
    chk("R11 default busy at cycle 8", {status[7], op_done}, 2'b00);
    @(negedge clk);
    chk("R11 default done", {status[7], op_done}, 2'b11);
    @(negedge clk);
  endtask

  initial begin
    fork
      run();
      begin
        repeat (20000) @(posedge clk);
        miscmp++;
        vectors++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
    $finish;
  end
endmodule